// File: doc/BRIEF.md
# Mixed-Width Two-Port RAM with Optional Read Pipeline

This block is a synchronous RAM with one write port and one read port on a single clock. The two ports have their own depth and data width, set by parameters. The only constraint is that both ports describe the same number of storage bits. Elaboration stops with an error if the two products differ, if either depth is outside 1 to 2048, or if the wider width is not a whole multiple of the narrower one. A narrow port sees the storage as more, smaller words. A wide port sees it as fewer, larger words built from consecutive narrow words.

The read path can carry two extra registers, each chosen by a static parameter. One register holds the read address before the storage array. The other holds the read data after the array. Each of these registers has three control pins:

- an active-high load enable;
- an active-low synchronous clear;
- an active-low asynchronous clear.

A register that is not built ignores its three control pins.

The block-select input on the read side and the write-enable input on the write side each have a polarity parameter and a presence parameter. When the presence parameter drops an input, that input is ignored and treated as permanently active.

Top module: `mixed_ram`

## Requirements
- R1: Every bit written through the write port is returned at the same bit location through the read port, across a full sweep of both address spaces.
- R2: Narrow address n refers to sub-word (n mod R) of wide word (n div R), where R is the width ratio; sub-word 0 occupies the least significant bits of the wide word.
- R3: With neither pipeline register built, read data appears one clock edge after the edge that samples the read address.
- R4: Each pipeline register that is built adds exactly one clock edge of read latency, so with both built the data appears three edges after the address is sampled.
- R5: When the storage read and a write to the same location happen on the same edge, the read returns the data held before that write.
- R6: With write enable present and active high, a write with the pin at 0 leaves storage unchanged. With write enable omitted, every edge writes, whatever the pin's value.
- R7: With block select present and active low, a pin value of 1 stops the storage read register from loading, so the read data holds. With block select omitted, the pin has no effect.
- R8: A built pipeline register whose enable is 0, with both clears inactive, keeps its value across edges.
- R9: A built pipeline register whose synchronous clear is 0 becomes zero at the next edge, even with its enable at 1.
- R10: A built pipeline register whose asynchronous clear is 0 reads zero at once, without waiting for a clock edge, and stays zero while the clear is held.
- R11: The enable and clear pins of a pipeline register that is not built have no effect on the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports and both pipeline registers |
| wr_en | input | 1 | Write enable; polarity set by WEN_POL, ignored when USE_WEN is 0 |
| wr_addr | input | clog2(WR_DEPTH), minimum 1 | Write word address |
| wr_data | input | WR_WIDTH | Write data |
| rd_bsel | input | 1 | Read block select; polarity set by BSEL_POL, ignored when USE_BSEL is 0 |
| rd_addr | input | clog2(RD_DEPTH), minimum 1 | Read word address |
| rd_data | output | RD_WIDTH | Read data |
| ap_en | input | 1 | Address register load enable, active high |
| ap_srst_n | input | 1 | Address register synchronous clear, active low |
| ap_arst_n | input | 1 | Address register asynchronous clear, active low |
| dp_en | input | 1 | Data register load enable, active high |
| dp_srst_n | input | 1 | Data register synchronous clear, active low |
| dp_arst_n | input | 1 | Data register asynchronous clear, active low |

## Verification
The hardest case to reach from the ports is a collision: the storage read edge must meet a write to the same bits. The address register moves that read edge one cycle after the address is presented. For this reason, the collision is driven on the unpipelined configuration, where the write and the read address can share one edge. A second read then confirms that the new value landed. The bench also needs different values in successive words so that each latency and hold check can tell old data from new. To get this, it fills storage with an odd-multiplier pattern that gives every narrow word its own value. It then moves between read addresses whose words differ while the select, enable or clear under test is held.

// File: rtl/mram_pkg.sv
package mram_pkg;

    typedef enum logic {
        ACT_LOW  = 1'b0,
        ACT_HIGH = 1'b1
    } pol_e;

    typedef struct packed {
        logic en;
        logic srst_n;
        logic arst_n;
    } stage_ctl_t;

    localparam int unsigned MAX_DEPTH = 2048;

    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth <= 1) ? 1 : $clog2(depth);
    endfunction

    function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_active(input logic pin, input pol_e pol, input bit present);
        return present ? (pin == logic'(pol)) : 1'b1;
    endfunction

endpackage

// File: rtl/mram_stage.sv
module mram_stage
    import mram_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter bit          ENABLE = 1'b0
) (
    input  logic         clk,
    input  stage_ctl_t   ctl,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (ENABLE) begin : g_reg
            logic         arst_n;
            logic [W-1:0] r;

            assign arst_n = ctl.arst_n;

            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    r <= '0;
                end else if (!ctl.srst_n) begin
                    r <= '0;
                end else if (ctl.en) begin
                    r <= d;
                end
            end

            assign q = r;
        end else begin : g_wire
            logic unused_ctl;
            assign unused_ctl = ^{clk, ctl};
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/mram_core.sv
module mram_core
    import mram_pkg::*;
#(
    parameter int unsigned WR_DEPTH = 64,
    parameter int unsigned WR_WIDTH = 8,
    parameter int unsigned RD_DEPTH = 32,
    parameter int unsigned RD_WIDTH = 16,
    localparam int unsigned WAW     = addr_bits(WR_DEPTH),
    localparam int unsigned RAW     = addr_bits(RD_DEPTH)
) (
    input  logic                clk,
    input  logic                we,
    input  logic [WAW-1:0]      waddr,
    input  logic [WR_WIDTH-1:0] wdata,
    input  logic                re,
    input  logic [RAW-1:0]      raddr,
    output logic [RD_WIDTH-1:0] rq
);

    localparam int unsigned UW    = min_u(WR_WIDTH, RD_WIDTH);
    localparam int unsigned UNITS = (WR_DEPTH * WR_WIDTH) / UW;
    localparam int unsigned UAW   = addr_bits(UNITS);
    localparam int unsigned WR_R  = WR_WIDTH / UW;
    localparam int unsigned RD_R  = RD_WIDTH / UW;

    logic [UW-1:0] mem [UNITS];

    // Write lanes: lane i of the wide word lands in unit (addr*R + i).
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < int'(WR_R); i++) begin
                mem[UAW'(waddr * WR_R + i)] <= wdata[i*UW +: UW];
            end
        end
    end

    // Registered read; nonblocking order yields pre-write data on a collision.
    always_ff @(posedge clk) begin
        if (re) begin
            for (int i = 0; i < int'(RD_R); i++) begin
                rq[i*UW +: UW] <= mem[UAW'(raddr * RD_R + i)];
            end
        end
    end

endmodule

// File: rtl/mixed_ram.sv
module mixed_ram
    import mram_pkg::*;
#(
    parameter int unsigned WR_DEPTH  = 64,
    parameter int unsigned WR_WIDTH  = 8,
    parameter int unsigned RD_DEPTH  = 32,
    parameter int unsigned RD_WIDTH  = 16,
    parameter bit          USE_BSEL  = 1'b0,
    parameter pol_e        BSEL_POL  = ACT_HIGH,
    parameter bit          USE_WEN   = 1'b0,
    parameter pol_e        WEN_POL   = ACT_HIGH,
    parameter bit          ADDR_PIPE = 1'b0,
    parameter bit          DATA_PIPE = 1'b0,
    localparam int unsigned WAW      = addr_bits(WR_DEPTH),
    localparam int unsigned RAW      = addr_bits(RD_DEPTH)
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [WAW-1:0]      wr_addr,
    input  logic [WR_WIDTH-1:0] wr_data,
    input  logic                rd_bsel,
    input  logic [RAW-1:0]      rd_addr,
    output logic [RD_WIDTH-1:0] rd_data,
    input  logic                ap_en,
    input  logic                ap_srst_n,
    input  logic                ap_arst_n,
    input  logic                dp_en,
    input  logic                dp_srst_n,
    input  logic                dp_arst_n
);

    localparam int unsigned NARROW = min_u(WR_WIDTH, RD_WIDTH);
    localparam int unsigned WIDE   = max_u(WR_WIDTH, RD_WIDTH);

    generate
        if (WR_DEPTH * WR_WIDTH != RD_DEPTH * RD_WIDTH) begin : g_bad_capacity
            $error("mixed_ram: write and read capacities differ");
        end
        if (WR_DEPTH < 1 || WR_DEPTH > MAX_DEPTH || RD_DEPTH < 1 || RD_DEPTH > MAX_DEPTH) begin : g_bad_depth
            $error("mixed_ram: port depth outside 1..2048");
        end
        if (WIDE % NARROW != 0) begin : g_bad_ratio
            $error("mixed_ram: wide width is not a multiple of narrow width");
        end
    endgenerate

    logic               wr_act;
    logic               rd_sel_act;
    logic [RAW-1:0]     addr_q;
    logic [RD_WIDTH-1:0] core_q;
    stage_ctl_t         ap_ctl;
    stage_ctl_t         dp_ctl;

    assign wr_act     = is_active(wr_en, WEN_POL, USE_WEN);
    assign rd_sel_act = is_active(rd_bsel, BSEL_POL, USE_BSEL);

    assign ap_ctl = '{en: ap_en, srst_n: ap_srst_n, arst_n: ap_arst_n};
    assign dp_ctl = '{en: dp_en, srst_n: dp_srst_n, arst_n: dp_arst_n};

    mram_stage #(.W(RAW), .ENABLE(ADDR_PIPE)) u_addr_stage (
        .clk (clk),
        .ctl (ap_ctl),
        .d   (rd_addr),
        .q   (addr_q)
    );

    mram_core #(
        .WR_DEPTH (WR_DEPTH),
        .WR_WIDTH (WR_WIDTH),
        .RD_DEPTH (RD_DEPTH),
        .RD_WIDTH (RD_WIDTH)
    ) u_core (
        .clk   (clk),
        .we    (wr_act),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (rd_sel_act),
        .raddr (addr_q),
        .rq    (core_q)
    );

    mram_stage #(.W(RD_WIDTH), .ENABLE(DATA_PIPE)) u_data_stage (
        .clk (clk),
        .ctl (dp_ctl),
        .d   (core_q),
        .q   (rd_data)
    );

endmodule

// File: rtl/mram_chk.sv
module mram_chk #(
    parameter int unsigned RAW       = 5,
    parameter int unsigned RD_WIDTH  = 16,
    parameter bit          ADDR_PIPE = 1'b0,
    parameter bit          DATA_PIPE = 1'b0
) (
    input logic                clk,
    input logic                ap_en,
    input logic                ap_srst_n,
    input logic                ap_arst_n,
    input logic                dp_en,
    input logic                dp_srst_n,
    input logic                dp_arst_n,
    input logic [RAW-1:0]      addr_q,
    input logic [RD_WIDTH-1:0] core_q,
    input logic                core_re,
    input logic [RD_WIDTH-1:0] rd_data
);

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (!dp_arst_n)
        !core_re |=> $stable(core_q));

    generate
        if (DATA_PIPE) begin : g_data_chk
            // R10
            data_aclr_chk: assert property (@(posedge clk)
                !dp_arst_n |-> rd_data == '0);
            // R9
            data_sclr_chk: assert property (@(posedge clk) disable iff (!dp_arst_n)
                !dp_srst_n |=> rd_data == '0);
            // R8
            data_hold_chk: assert property (@(posedge clk) disable iff (!dp_arst_n)
                (dp_srst_n && !dp_en) |=> $stable(rd_data));
        end
        if (ADDR_PIPE) begin : g_addr_chk
            // R10
            addr_aclr_chk: assert property (@(posedge clk)
                !ap_arst_n |-> addr_q == '0);
            // R9
            addr_sclr_chk: assert property (@(posedge clk) disable iff (!ap_arst_n)
                !ap_srst_n |=> addr_q == '0);
            // R8
            addr_hold_chk: assert property (@(posedge clk) disable iff (!ap_arst_n)
                (ap_srst_n && !ap_en) |=> $stable(addr_q));
        end
    endgenerate

endmodule

bind mixed_ram mram_chk #(
    .RAW       (RAW),
    .RD_WIDTH  (RD_WIDTH),
    .ADDR_PIPE (ADDR_PIPE),
    .DATA_PIPE (DATA_PIPE)
) u_chk (
    .clk       (clk),
    .ap_en     (ap_en),
    .ap_srst_n (ap_srst_n),
    .ap_arst_n (ap_arst_n),
    .dp_en     (dp_en),
    .dp_srst_n (dp_srst_n),
    .dp_arst_n (dp_arst_n),
    .addr_q    (addr_q),
    .core_q    (core_q),
    .core_re   (rd_sel_act),
    .rd_data   (rd_data)
);

// File: tb/mixed_ram_bench.sv
module mixed_ram_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Configuration A: 8-bit write x64, 16-bit read x32, both pipes, select active low, write enable active high
    logic [5:0]  a_waddr;
    logic [7:0]  a_wdata;
    logic        a_wen;
    logic [4:0]  a_raddr;
    logic        a_bsel;
    logic [15:0] a_rdata;
    logic a_ap_en, a_ap_srst_n, a_ap_arst_n, a_dp_en, a_dp_srst_n, a_dp_arst_n;

    // Configuration B: 16-bit write x32, 8-bit read x64, no pipes, select and write enable omitted
    logic [4:0]  b_waddr;
    logic [15:0] b_wdata;
    logic        b_wen;
    logic [5:0]  b_raddr;
    logic        b_bsel;
    logic [7:0]  b_rdata;
    logic b_ap_en, b_ap_srst_n, b_ap_arst_n, b_dp_en, b_dp_srst_n, b_dp_arst_n;

    logic [511:0] ma;
    logic [511:0] mb;

    mixed_ram #(
        .WR_DEPTH(64), .WR_WIDTH(8), .RD_DEPTH(32), .RD_WIDTH(16),
        .USE_BSEL(1'b1), .BSEL_POL(mram_pkg::ACT_LOW),
        .USE_WEN(1'b1), .WEN_POL(mram_pkg::ACT_HIGH),
        .ADDR_PIPE(1'b1), .DATA_PIPE(1'b1)
    ) u_mixed_ram (
        .clk(clk), .wr_en(a_wen), .wr_addr(a_waddr), .wr_data(a_wdata),
        .rd_bsel(a_bsel), .rd_addr(a_raddr), .rd_data(a_rdata),
        .ap_en(a_ap_en), .ap_srst_n(a_ap_srst_n), .ap_arst_n(a_ap_arst_n),
        .dp_en(a_dp_en), .dp_srst_n(a_dp_srst_n), .dp_arst_n(a_dp_arst_n)
    );

    mixed_ram #(
        .WR_DEPTH(32), .WR_WIDTH(16), .RD_DEPTH(64), .RD_WIDTH(8),
        .USE_BSEL(1'b0), .BSEL_POL(mram_pkg::ACT_HIGH),
        .USE_WEN(1'b0), .WEN_POL(mram_pkg::ACT_HIGH),
        .ADDR_PIPE(1'b0), .DATA_PIPE(1'b0)
    ) u_mixed_ram_flat (
        .clk(clk), .wr_en(b_wen), .wr_addr(b_waddr), .wr_data(b_wdata),
        .rd_bsel(b_bsel), .rd_addr(b_raddr), .rd_data(b_rdata),
        .ap_en(b_ap_en), .ap_srst_n(b_ap_srst_n), .ap_arst_n(b_ap_arst_n),
        .dp_en(b_dp_en), .dp_srst_n(b_dp_srst_n), .dp_arst_n(b_dp_arst_n)
    );

    function automatic logic [7:0] fa(input int a);
        return 8'(a * 29 + 3);
    endfunction

    function automatic logic [15:0] fb(input int w);
        return 16'(w * 1237 + 91);
    endfunction

    function automatic logic [15:0] wa(input int r);
        return ma[r*16 +: 16];
    endfunction

    function automatic logic [7:0] nb(input int n);
        return mb[n*8 +: 8];
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic a_read(input int r, input string tag);
        @(negedge clk) a_raddr = 5'(r);
        repeat (3) @(negedge clk);
        chk(tag, a_rdata, wa(r));
    endtask

    initial begin
        a_waddr = '0; a_wdata = '0; a_wen = 1'b0; a_raddr = '0; a_bsel = 1'b0;
        a_ap_en = 1'b1; a_ap_srst_n = 1'b0; a_ap_arst_n = 1'b0;
        a_dp_en = 1'b1; a_dp_srst_n = 1'b0; a_dp_arst_n = 1'b0;
        b_waddr = '0; b_wdata = '0; b_wen = 1'b0; b_raddr = '0; b_bsel = 1'b0;
        b_ap_en = 1'b1; b_ap_srst_n = 1'b1; b_ap_arst_n = 1'b1;
        b_dp_en = 1'b1; b_dp_srst_n = 1'b1; b_dp_arst_n = 1'b1;
        ma = '0; mb = '0;

        repeat (2) @(negedge clk);
        chk("R10 reset state", a_rdata, 16'h0000);
        a_ap_srst_n = 1'b1; a_ap_arst_n = 1'b1; a_dp_srst_n = 1'b1; a_dp_arst_n = 1'b1;

        // Fill configuration A through the narrow write port
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            a_waddr = 6'(a); a_wdata = fa(a); a_wen = 1'b1;
            ma[a*8 +: 8] = fa(a);
        end
        @(negedge clk) a_wen = 1'b0;
        // R6: write with the enable inactive must not land
        @(negedge clk) begin a_waddr = 6'd6; a_wdata = 8'hEE; end
        @(negedge clk);

        // R1 R2: full wide-read sweep
        for (int r = 0; r < 32; r++) a_read(r, "R1 R2 sweep");
        a_read(3, "R6 write ignored");

        // R4: three-edge latency
        @(negedge clk) a_raddr = 5'd4;
        repeat (2) @(negedge clk);
        chk("R4 not yet", a_rdata, wa(3));
        @(negedge clk);
        chk("R4 arrival", a_rdata, wa(4));

        // R7: select inactive holds
        @(negedge clk) begin a_bsel = 1'b1; a_raddr = 5'd9; end
        repeat (4) @(negedge clk);
        chk("R7 select hold", a_rdata, wa(4));
        @(negedge clk) a_bsel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 select resume", a_rdata, wa(9));

        // R8: address register hold
        @(negedge clk) begin a_ap_en = 1'b0; a_raddr = 5'd12; end
        repeat (4) @(negedge clk);
        chk("R8 addr hold", a_rdata, wa(9));
        @(negedge clk) a_ap_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 addr resume", a_rdata, wa(12));

        // R8: data register hold
        @(negedge clk) begin a_dp_en = 1'b0; a_raddr = 5'd15; end
        repeat (4) @(negedge clk);
        chk("R8 data hold", a_rdata, wa(12));
        @(negedge clk) a_dp_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 data resume", a_rdata, wa(15));

        // R9: data synchronous clear beats enable
        @(negedge clk) a_dp_srst_n = 1'b0;
        @(negedge clk);
        chk("R9 data clear", a_rdata, 16'h0000);
        a_dp_srst_n = 1'b1;
        @(negedge clk);
        chk("R9 data after clear", a_rdata, wa(15));

        // R9: address synchronous clear sends word 0 down the pipe
        @(negedge clk) a_ap_srst_n = 1'b0;
        @(negedge clk) a_ap_srst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 addr clear", a_rdata, wa(0));
        @(negedge clk);
        chk("R9 addr after clear", a_rdata, wa(15));

        // R10: asynchronous clear acts before any edge
        @(negedge clk) a_dp_arst_n = 1'b0;
        #1;
        chk("R10 data async", a_rdata, 16'h0000);
        @(negedge clk) a_dp_arst_n = 1'b1;
        @(negedge clk);
        chk("R10 data release", a_rdata, wa(15));
        @(negedge clk) a_ap_arst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 addr async", a_rdata, wa(0));
        a_ap_arst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 addr release", a_rdata, wa(15));

        // Configuration B: wide write, write enable omitted (pin held at 0)
        for (int w = 0; w < 32; w++) begin
            @(negedge clk);
            b_waddr = 5'(w); b_wdata = fb(w); b_wen = 1'b0;
            mb[w*16 +: 16] = fb(w);
        end
        // R1 R2 R3: narrow-read sweep at one-edge latency
        for (int n = 0; n < 64; n++) begin
            @(negedge clk) begin b_raddr = 6'(n); b_bsel = n[0]; end
            @(negedge clk);
            chk("R1 R2 R3 R6 R7 narrow sweep", {8'h00, b_rdata}, {8'h00, nb(n)});
        end

        // R5: read and write the same bits on one edge
        @(negedge clk) begin b_waddr = 5'd7; b_wdata = 16'hA55A; b_raddr = 6'd15; end
        @(negedge clk);
        chk("R5 old data", {8'h00, b_rdata}, {8'h00, nb(15)});
        mb[7*16 +: 16] = 16'hA55A;
        @(negedge clk);
        chk("R5 new data", {8'h00, b_rdata}, 16'h00A5);

        // R11: controls of absent registers do nothing
        @(negedge clk) begin
            b_ap_arst_n = 1'b0; b_dp_arst_n = 1'b0; b_ap_srst_n = 1'b0;
            b_dp_srst_n = 1'b0; b_ap_en = 1'b0; b_dp_en = 1'b0;
        end
        #1;
        chk("R11 async pins", {8'h00, b_rdata}, 16'h00A5);
        @(negedge clk) b_raddr = 6'd20;
        @(negedge clk);
        chk("R11 read through", {8'h00, b_rdata}, {8'h00, nb(20)});

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule